// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Break-Before-Make Switching

This block drives a set of 8-pin I/O ports from a processor register bus. For each port it holds a direction register and an output register. The output register's bit means either the driven level or the pull-up request, depending on direction. Pad levels are sampled through a two-stage synchronizer and can be read back. A control register holds per-port pull-up disables and per-port break-before-make enables. A separate global register holds a single pull-up disable for every port.

When break-before-make is on for a port, a register write that turns a pin from input to output keeps the pad driver off for one intermediate cycle before the driver is enabled. The block also takes enable requests from interrupt logic: external-interrupt enables per pin, pin-change masks per pin and a pin-change enable per port. Any of these forces the pin's digital input buffer on, even where the pin's digital input has been switched off for analog use. The synchronized pin value is then passed to the interrupt logic.

Top module: `gpio_bbm_top`

## Requirements
- R1: A pin's pull-up (`pad_pue`) is 1 only when its direction bit is 0, its output-register bit is 1 and no disable applies to its port. Every other direction/output combination gives 0.
- R2: With the global pull-up disable set (bit 0 at address 13), `pad_pue` is 0 on every pin of every port.
- R3: Control-register bit p (address 12, bits 3:0) turns off the pull-ups of port p only. It is ORed with the global disable, and pull-ups on the other ports are unaffected.
- R4: With control bit 4+p set, a direction write that changes a pin of port p from 0 to 1 gives exactly one sampled cycle with `pad_oe` 0 after the write, then `pad_oe` 1. Pins already at 1 stay driven.
- R5: With break-before-make off for a port, `pad_oe` follows a new direction value in the cycle right after the write.
- R6: A direction change from 1 to 0 drops `pad_oe` in the cycle right after the write, even with break-before-make enabled.
- R7: During the inserted break-before-make cycle, `pad_pue` follows the normal rule for the new register values (0, since the direction bit is 1). `pad_out` carries the output-register value throughout.
- R8: `pad_die` is 1 when the pin's `xint_en` bit is set, or when both its `pc_mask` bit and its port's `pc_port_en` bit are set. Otherwise it is the inverse of `din_off`.
- R9: Reading address 3p+2 returns port p's pad levels two clock edges after they change. Any pin with `pad_die` 0 reads 0, and the same gated value appears on `irq_pin_val`.
- R10: After reset, all direction, output, control and global registers read 0, and `pad_oe` and `pad_pue` are 0.
- R11: Port p's direction register is at address 3p and its output register at 3p+1. The control register is at 12 and the global disable at 13. Each of them reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Pad input levels, 8 per port, port 0 in the low byte |
| din_off | input | 32 | Per-pin request to switch the digital input buffer off |
| xint_en | input | 32 | Per-pin external-interrupt enable |
| pc_mask | input | 32 | Per-pin pin-change mask |
| pc_port_en | input | 4 | Per-port pin-change enable |
| pad_oe | output | 32 | Pad output-driver enable |
| pad_out | output | 32 | Pad output level |
| pad_pue | output | 32 | Pad pull-up enable |
| pad_die | output | 32 | Pad digital-input enable |
| irq_pin_val | output | 32 | Gated synchronized pin values for interrupt logic |

## Verification
The bench runs all four direction/output combinations at once on each port under four disable settings: none, global, the port's own bit and another port's bit. A wrong OR of the disables, or a disable decoded onto the wrong port, shows up as a stray or missing pull-up. Break-before-make is checked cycle by cycle on a mixed write, where some pins are already outputs and others are turning on. A design that held the driver for zero or two cycles, held pins that were already driven, or delayed the output-to-input turn-off would fail there. The digital-input override is checked with the pin-change port enable both off and on, and pin reads are sampled one and two edges after a pad change to pin down the synchronizer latency.

// File: rtl/gpio_bbm_pkg.sv
package gpio_bbm_pkg;
  localparam int REGS_PER_PORT = 3;
  localparam int OFF_DIR       = 0;
  localparam int OFF_OUT       = 1;
  localparam int OFF_PIN       = 2;
endpackage

// File: rtl/gpio_bbm_rstsync.sv
module gpio_bbm_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_bbm_ctrl.sv
module gpio_bbm_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic                 gbl_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [2*NUM_PORTS-1:0] ctrl_q,
  output logic                 gpud_q,
  output logic [NUM_PORTS-1:0] bbm_en,
  output logic [NUM_PORTS-1:0] port_dis
);
  localparam int CTRL_W = 2 * NUM_PORTS;

  logic [CTRL_W-1:0] ctrl_d;
  logic              gpud_d;

  always_comb begin
    ctrl_d = ctrl_q;
    gpud_d = gpud_q;
    if (ctrl_we) ctrl_d = wdata[CTRL_W-1:0];
    if (gbl_we)  gpud_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gpud_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      gpud_q <= gpud_d;
    end
  end

  assign bbm_en   = ctrl_q[CTRL_W-1:NUM_PORTS];
  assign port_dis = ctrl_q[NUM_PORTS-1:0] | {NUM_PORTS{gpud_q}};

  // R2: global disable reaches every port
  p_gbl_dis_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gpud_q |-> (&port_dis));
endmodule

// File: rtl/gpio_bbm_bank.sv
module gpio_bbm_bank #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_we,
  input  logic              out_we,
  input  logic [PORT_W-1:0] wdata,
  input  logic              bbm_en,
  input  logic              pu_dis,
  input  logic              pc_en,
  input  logic [PORT_W-1:0] pad_in,
  input  logic [PORT_W-1:0] din_off,
  input  logic [PORT_W-1:0] xint_en,
  input  logic [PORT_W-1:0] pc_mask,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] pin_rd,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_pue,
  output logic [PORT_W-1:0] pad_die
);
  logic [PORT_W-1:0] dir_d, out_d, hold_d, hold_q;
  logic [PORT_W-1:0] sync1_q, sync2_q, ovr;

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    hold_d = '0;
    if (dir_we) begin
      dir_d = wdata;
      if (bbm_en) hold_d = wdata & ~dir_q;
    end
    if (out_we) out_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      hold_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      hold_q  <= hold_d;
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign ovr     = xint_en | (pc_mask & {PORT_W{pc_en}});
  assign pad_die = ovr | ~din_off;
  assign pin_rd  = sync2_q & pad_die;
  assign pad_oe  = dir_q & ~hold_q;
  assign pad_out = out_q;
  assign pad_pue = ~dir_q & out_q & {PORT_W{~pu_dis}};

  // R1: pull-up only on an input pin with its output bit set
  p_pue_rule_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pue & (dir_q | ~out_q)) == '0);
  // R3: port disable kills the port's pull-ups
  p_port_dis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pu_dis |-> (pad_pue == '0));
  // R4: the hold never lasts two cycles on the same pin
  p_hold_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |=> ((hold_q & $past(hold_q)) == '0));
  // R4: a pin newly turned to output is not driven in the first cycle
  p_bbm_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && bbm_en) |=> ((pad_oe & $past(wdata & ~dir_q)) == '0));
  // R6: clearing a direction bit drops the driver at once
  p_oe_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> ((pad_oe & ~$past(wdata)) == '0));
  // R9: a pin with its input buffer off reads 0
  p_pin_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rd & ~pad_die) == '0);
endmodule

// File: rtl/gpio_bbm_top.sv
module gpio_bbm_top
  import gpio_bbm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  input  logic [NUM_PORTS*PORT_W-1:0] din_off,
  input  logic [NUM_PORTS*PORT_W-1:0] xint_en,
  input  logic [NUM_PORTS*PORT_W-1:0] pc_mask,
  input  logic [NUM_PORTS-1:0]        pc_port_en,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_pue,
  output logic [NUM_PORTS*PORT_W-1:0] pad_die,
  output logic [NUM_PORTS*PORT_W-1:0] irq_pin_val
);
  localparam int CTRL_ADDR = NUM_PORTS * REGS_PER_PORT;
  localparam int GBL_ADDR  = CTRL_ADDR + 1;
  localparam int CTRL_W    = 2 * NUM_PORTS;
  localparam int TOTAL_W   = NUM_PORTS * PORT_W;

  logic                   srst_n;
  logic [CTRL_W-1:0]      ctrl_q;
  logic                   gpud_q;
  logic [NUM_PORTS-1:0]   bbm_en, port_dis;
  logic [TOTAL_W-1:0]     dir_all, out_all, pin_all;
  logic                   ctrl_we, gbl_we;

  assign ctrl_we = bus_we && (int'(bus_addr) == CTRL_ADDR);
  assign gbl_we  = bus_we && (int'(bus_addr) == GBL_ADDR);

  gpio_bbm_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gpio_bbm_ctrl #(.NUM_PORTS(NUM_PORTS), .DATA_W(PORT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .ctrl_we  (ctrl_we),
    .gbl_we   (gbl_we),
    .wdata    (bus_wdata),
    .ctrl_q   (ctrl_q),
    .gpud_q   (gpud_q),
    .bbm_en   (bbm_en),
    .port_dis (port_dis)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic dir_we, out_we;
    assign dir_we = bus_we && (int'(bus_addr) == p*REGS_PER_PORT + OFF_DIR);
    assign out_we = bus_we && (int'(bus_addr) == p*REGS_PER_PORT + OFF_OUT);

    gpio_bbm_bank #(.PORT_W(PORT_W)) u_bank (
      .clk     (clk),
      .rst_n   (srst_n),
      .dir_we  (dir_we),
      .out_we  (out_we),
      .wdata   (bus_wdata),
      .bbm_en  (bbm_en[p]),
      .pu_dis  (port_dis[p]),
      .pc_en   (pc_port_en[p]),
      .pad_in  (pad_in [p*PORT_W +: PORT_W]),
      .din_off (din_off[p*PORT_W +: PORT_W]),
      .xint_en (xint_en[p*PORT_W +: PORT_W]),
      .pc_mask (pc_mask[p*PORT_W +: PORT_W]),
      .dir_q   (dir_all[p*PORT_W +: PORT_W]),
      .out_q   (out_all[p*PORT_W +: PORT_W]),
      .pin_rd  (pin_all[p*PORT_W +: PORT_W]),
      .pad_oe  (pad_oe [p*PORT_W +: PORT_W]),
      .pad_out (pad_out[p*PORT_W +: PORT_W]),
      .pad_pue (pad_pue[p*PORT_W +: PORT_W]),
      .pad_die (pad_die[p*PORT_W +: PORT_W])
    );
  end

  assign irq_pin_val = pin_all;

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(bus_addr) == p*REGS_PER_PORT + OFF_DIR) bus_rdata = dir_all[p*PORT_W +: PORT_W];
      if (int'(bus_addr) == p*REGS_PER_PORT + OFF_OUT) bus_rdata = out_all[p*PORT_W +: PORT_W];
      if (int'(bus_addr) == p*REGS_PER_PORT + OFF_PIN) bus_rdata = pin_all[p*PORT_W +: PORT_W];
    end
    if (int'(bus_addr) == CTRL_ADDR) bus_rdata = PORT_W'(ctrl_q);
    if (int'(bus_addr) == GBL_ADDR)  bus_rdata = PORT_W'(gpud_q);
  end

  // R10: nothing driven or pulled while held in reset
  p_reset_idle_r10: assert property (@(posedge clk)
    !srst_n |-> (pad_oe == '0 && pad_pue == '0));
endmodule

// File: tb/gpio_bbm_top_tb.sv
`timescale 1ns/100ps
module gpio_bbm_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [31:0] pad_in, din_off, xint_en, pc_mask;
  logic [3:0]  pc_port_en;
  logic [31:0] pad_oe, pad_out, pad_pue, pad_die, irq_pin_val;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] m_dir [4];
  logic [7:0] m_out [4];
  logic [7:0] m_ctrl;
  logic       m_gbl;

  always #2.5 clk = ~clk;

  gpio_bbm_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .din_off(din_off), .xint_en(xint_en), .pc_mask(pc_mask),
    .pc_port_en(pc_port_en), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pue(pad_pue), .pad_die(pad_die), .irq_pin_val(irq_pin_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[3:0]; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a < 12 && a % 3 == 0) m_dir[a/3] = d;
    if (a < 12 && a % 3 == 1) m_out[a/3] = d;
    if (a == 12) m_ctrl = d;
    if (a == 13) m_gbl = d[0];
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    bus_addr = a[3:0];
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_pue();
    logic [31:0] r;
    for (int q = 0; q < 4; q++) begin
      logic dis;
      dis = m_gbl | m_ctrl[q];
      r[q*8 +: 8] = ~m_dir[q] & m_out[q] & {8{~dis}};
    end
    return r;
  endfunction

  task automatic clear_all();
    for (int q = 0; q < 4; q++) begin
      bus_write(3*q, 8'h00);
      bus_write(3*q+1, 8'h00);
    end
    bus_write(12, 8'h00);
    bus_write(13, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 oe", pad_oe, 32'h0);
    check("R10 pue", pad_pue, 32'h0);
    for (int a = 0; a < 14; a++) begin
      if (a % 3 != 2 || a >= 12) begin
        bus_read(a, d);
        check($sformatf("R10 reg %0d", a), {24'h0, d}, 32'h0);
      end
    end
  endtask

  task automatic t_pullup_matrix();
    for (int p = 0; p < 4; p++) begin
      clear_all();
      bus_write(3*p, 8'h0F);
      bus_write(3*p+1, 8'h33);
      for (int q = 0; q < 4; q++)
        if (q != p) bus_write(3*q+1, 8'hFF);
      for (int mode = 0; mode < 4; mode++) begin
        bus_write(13, (mode == 1) ? 8'h01 : 8'h00);
        bus_write(12, (mode == 2) ? 8'(1 << p) :
                      (mode == 3) ? 8'(1 << ((p + 1) % 4)) : 8'h00);
        case (mode)
          0: check($sformatf("R1 port %0d", p), pad_pue, exp_pue());
          1: check($sformatf("R2 port %0d", p), pad_pue, exp_pue());
          default: check($sformatf("R3 port %0d mode %0d", p, mode), pad_pue, exp_pue());
        endcase
      end
    end
  endtask

  task automatic t_bbm_switch();
    clear_all();
    bus_write(12, 8'h20);
    bus_write(4, 8'hFF);
    bus_write(3, 8'h0F);
    check("R4 first gap", pad_oe, 32'h0);
    @(negedge clk);
    check("R4 first drive", pad_oe, 32'h0000_0F00);
    bus_write(3, 8'hFF);
    check("R4 mixed gap", pad_oe, 32'h0000_0F00);
    check("R7 pue in gap", pad_pue, 32'h0);
    check("R7 out in gap", pad_out, 32'h0000_FF00);
    @(negedge clk);
    check("R4 mixed drive", pad_oe, 32'h0000_FF00);
    @(negedge clk);
    check("R4 stays driven", pad_oe, 32'h0000_FF00);
  endtask

  task automatic t_out_to_in();
    bus_write(3, 8'h3C);
    check("R6 immediate off", pad_oe, 32'h0000_3C00);
    bus_write(3, 8'h00);
    check("R6 all off", pad_oe, 32'h0);
  endtask

  task automatic t_no_bbm();
    clear_all();
    bus_write(12, 8'h20);
    bus_write(0, 8'hAA);
    check("R5 direct drive", pad_oe, 32'h0000_00AA);
  endtask

  task automatic t_die_override();
    din_off = 32'hFFFF_FFFF; xint_en = '0; pc_mask = '0; pc_port_en = '0;
    @(negedge clk);
    check("R8 all off", pad_die, 32'h0);
    xint_en = 32'h0000_0004;
    pc_mask = 32'h0000_0200;
    @(negedge clk);
    check("R8 xint only", pad_die, 32'h0000_0004);
    pc_port_en = 4'b0010;
    @(negedge clk);
    check("R8 pc mask and enable", pad_die, 32'h0000_0204);
    din_off = 32'hFFFF_0FFF;
    @(negedge clk);
    check("R8 normal enable", pad_die, 32'h0000_F204);
    din_off = '0; xint_en = '0; pc_mask = '0; pc_port_en = '0;
  endtask

  task automatic t_pin_read();
    logic [7:0] d;
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    pad_in = 32'hA5C3_5A3C;
    @(negedge clk);
    bus_read(2, d);
    check("R9 one edge", {24'h0, d}, 32'h0);
    @(negedge clk);
    bus_read(2, d);
    check("R9 two edges", {24'h0, d}, 32'h3C);
    bus_read(11, d);
    check("R9 port 3", {24'h0, d}, 32'hA5);
    din_off = 32'h0000_00F0;
    #0.5;
    bus_read(2, d);
    check("R9 gated", {24'h0, d}, 32'h0C);
    check("R9 irq value", irq_pin_val, 32'hA5C3_5A0C);
    din_off = '0;
  endtask

  task automatic t_readback();
    logic [7:0] d;
    bus_write(6, 8'h5A);
    bus_write(10, 8'hC3);
    bus_write(12, 8'h96);
    bus_write(13, 8'h01);
    bus_read(6, d);  check("R11 dir port2", {24'h0, d}, 32'h5A);
    bus_read(10, d); check("R11 out port3", {24'h0, d}, 32'hC3);
    bus_read(12, d); check("R11 ctrl", {24'h0, d}, 32'h96);
    bus_read(13, d); check("R11 global", {24'h0, d}, 32'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; din_off = '0; xint_en = '0; pc_mask = '0; pc_port_en = '0;
    for (int q = 0; q < 4; q++) begin m_dir[q] = '0; m_out[q] = '0; end
    m_ctrl = '0; m_gbl = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pullup_matrix();
    t_bbm_switch();
    t_out_to_in();
    t_no_bbm();
    t_die_override();
    t_pin_read();
    t_readback();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule